// File: doc/BRIEF.md
# Asynchronous Memory Bus Controller with Turnaround Insertion

This block converts internal read and write requests of either 32 or 16 bits into cycles on an external asynchronous memory bus that is 16 bits wide and has one chip select per device. A request is offered with a valid/ready handshake. It carries a direction, a width, a chip-select index, a halfword address, write data and byte enables. The controller runs the request through programmable setup, strobe and hold phases. It drives the active-low chip select, output enable, write enable and byte-lane masks, along with the address. The write data goes out on a shared bidirectional data bus.

A 32-bit request becomes two 16-bit accesses, the lower half first at the given address and the upper half at the next address. Chip select is released between the two halves. Before each access the controller compares the new access with the one just completed. A change of chip select, or a read followed by a write on the same device, adds a programmable turnaround gap. A read returns a single response pulse carrying the assembled data. All timing counts come from input ports and are expected to stay steady while the controller is busy.

Top module: `amc_ctrl`

## Requirements
- R1: `req_ready` is high only when the controller is idle with no upper half pending. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and requests are executed in the order taken.
- R2: Every access runs setup, strobe and hold phases in that order, lasting `cfg_setup`+1, `cfg_strobe`+1 and `cfg_hold`+1 clocks.
- R3: `mem_oe_n` is low only in the strobe phase of a read and `mem_we_n` only in the strobe phase of a write. The two are never low together, and neither is low without a chip select.
- R4: A turnaround is inserted when the chip select changes, in all four direction pairings, and when a read is followed by a write to the same chip select. With the next request already waiting, the all-deselected gap between the two accesses is `cfg_turn`+2 clocks.
- R5: No turnaround is inserted between two reads, two writes, or a write then a read on the same chip select. With the next request waiting, the gap is exactly one clock.
- R6: A 32-bit request (`req_wide`=1) is carried out as two 16-bit accesses, first at `req_addr` with bits 15:0, then at `req_addr`+1 with bits 31:16. The address is steady throughout each access.
- R7: At most one chip select is low at a time, chip select `mem_cs_n[i]` belongs to index i, and it stays low unchanged from the first setup cycle to the last hold cycle. It rises for at least one clock between any two accesses, including the two halves of a split request.
- R8: During an access `mem_dqm_n` is 2'b00 for a read. For a write it is the inverse of the enables of that half: `req_be[1:0]` for bits 15:0 and `req_be[3:2]` for bits 31:16, bit 0 covering the lower byte. It is 2'b11 when no chip select is low.
- R9: During a write access the controller drives the half's data on `mem_data` from the first setup cycle to the last hold cycle. During a read it leaves the bus undriven.
- R10: Read data is taken from `mem_data` in the last strobe cycle. `rsp_valid` pulses for one clock, in the clock after the last hold cycle of a read's final half. `rsp_rdata` is {upper, lower} for a 32-bit read and {16'h0000, lower} for a 16-bit read.
- R11: After reset all chip selects, `mem_oe_n` and `mem_we_n` are high, `mem_dqm_n` is 2'b11, `rsp_valid` is low, `req_ready` is high, and the first access has no turnaround.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit request, 0 = 16-bit |
| req_cs | input | CS_W (2) | Chip-select index |
| req_addr | input | ADDR_W (20) | Halfword address |
| req_wdata | input | WORD_W (32) | Write data, bits 15:0 for the first half |
| req_be | input | 2*LANES (4) | Active-high byte enables for the write |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | WORD_W (32) | Assembled read data |
| cfg_setup | input | CNT_W (4) | Setup clocks minus one |
| cfg_strobe | input | CNT_W (4) | Strobe clocks minus one |
| cfg_hold | input | CNT_W (4) | Hold clocks minus one |
| cfg_turn | input | CNT_W (4) | Turnaround clocks minus one |
| mem_cs_n | output | NUM_CS (4) | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dqm_n | output | LANES (2) | Active-low byte-lane masks |
| mem_addr | output | ADDR_W (20) | External halfword address |
| mem_data | inout | HALF_W (16) | Bidirectional external data bus |

## Verification
The hardest situation to reach is an exact measurement of the gap between two accesses. That measurement is only meaningful when the next request is already waiting as the previous access finishes, and without it the turnaround rule cannot be told apart from idle time. The stimulus therefore offers each request the moment the previous one is taken. A directed run walks every previous/next pairing of direction and chip select, including writes after writes and reads after writes on one device. Randomized batches then vary the four timing counts, including all zeros, and mix split and single requests with partial byte enables, so the upper-half capture and the released chip select between halves are exercised under many timings.

// File: rtl/amc_pkg.sv
// Package: shared types for the asynchronous memory bus controller.
// Assumes: nothing beyond IEEE 1800-2017.
package amc_pkg;

    // Bus phase of the controller; every access walks SETUP, STROBE, HOLD.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } amc_state_e;

endpackage

// File: rtl/amc_turn_rule.sv
// Module: decides whether a turnaround gap precedes the next access.
// A gap is needed when the chip select changes, or on a read followed by
// a write to the same chip select. Assumes prev_* describe the last
// completed access and prev_valid is low until one has completed.
module amc_turn_rule #(
    parameter int CS_W = 2
) (
    input  logic            prev_valid,
    input  logic            prev_write,
    input  logic [CS_W-1:0] prev_cs,
    input  logic            next_write,
    input  logic [CS_W-1:0] next_cs,
    output logic            need_turn
);

    // Compare previous and next access and flag a required gap.
    always_comb begin
        need_turn = 1'b0;
        if (prev_valid) begin
            need_turn = (prev_cs != next_cs) || (!prev_write && next_write);
        end
    end

endmodule

// File: rtl/amc_phase_cnt.sv
// Module: shared phase length counter. Counts clocks while run is high and
// flags the last clock of the phase when the count reaches limit. It
// restarts after each last clock, so back-to-back phases need no reload.
// Assumes limit is steady during a phase.
module amc_phase_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    assign last = run && (cnt == limit);

    // Advance the count inside a phase and clear it at the phase end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/amc_lane_mux.sv
// Module: selects the 16-bit half of a 32-bit write word and its byte-lane
// masks. Reads enable every lane. Assumes HALF_W is a multiple of 8.
module amc_lane_mux #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0]   wdata,
    input  logic [HALF_W/4-1:0]   be,
    input  logic                  upper,
    input  logic                  write,
    output logic [HALF_W-1:0]     half_data,
    output logic [HALF_W/8-1:0]   half_mask_n
);

    localparam int LANES = HALF_W / 8;

    // Pick the data half and invert its enables into active-low masks.
    always_comb begin
        half_data   = upper ? wdata[2*HALF_W-1:HALF_W] : wdata[HALF_W-1:0];
        half_mask_n = '0;
        if (write) begin
            half_mask_n = upper ? ~be[2*LANES-1:LANES] : ~be[LANES-1:0];
        end
    end

endmodule

// File: rtl/amc_ctrl.sv
// Module: asynchronous memory bus controller (top). Takes 16- or 32-bit
// requests by valid/ready, splits 32-bit ones into two halves (lower
// first), and runs each half as setup/strobe/hold with a mandatory idle
// clock between accesses and an optional turnaround before it.
// Assumes cfg_* stay steady while an access is in progress and that the
// external device drives mem_data only while mem_oe_n is low.
module amc_ctrl
    import amc_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 20,
    parameter int HALF_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic                       req_wide,
    input  logic [$clog2(NUM_CS)-1:0]  req_cs,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [2*HALF_W-1:0]        req_wdata,
    input  logic [HALF_W/4-1:0]        req_be,
    output logic                       rsp_valid,
    output logic [2*HALF_W-1:0]        rsp_rdata,
    input  logic [CNT_W-1:0]           cfg_setup,
    input  logic [CNT_W-1:0]           cfg_strobe,
    input  logic [CNT_W-1:0]           cfg_hold,
    input  logic [CNT_W-1:0]           cfg_turn,
    output logic [NUM_CS-1:0]          mem_cs_n,
    output logic                       mem_oe_n,
    output logic                       mem_we_n,
    output logic [HALF_W/8-1:0]        mem_dqm_n,
    output logic [ADDR_W-1:0]          mem_addr,
    inout  wire  [HALF_W-1:0]          mem_data
);

    localparam int CS_W   = $clog2(NUM_CS);
    localparam int WORD_W = 2 * HALF_W;
    localparam int LANES  = HALF_W / 8;

    amc_state_e          state;
    logic                cur_write, cur_wide, upper, pend_hi;
    logic [CS_W-1:0]     cur_cs;
    logic [ADDR_W-1:0]   cur_addr;
    logic [WORD_W-1:0]   cur_wdata;
    logic [2*LANES-1:0]  cur_be;
    logic                prev_valid, prev_write;
    logic [CS_W-1:0]     prev_cs;
    logic [HALF_W-1:0]   rd_lo, rd_hi;
    logic                rsp_q;

    logic                nxt_write, need_turn, start, in_acc, phase_last;
    logic [CS_W-1:0]     nxt_cs;
    logic [CNT_W-1:0]    phase_limit;
    logic [HALF_W-1:0]   half_data;
    logic [LANES-1:0]    half_mask_n;

    // Source of the next access: a pending upper half or a new request.
    always_comb begin
        nxt_write = pend_hi ? cur_write : req_write;
        nxt_cs    = pend_hi ? cur_cs    : req_cs;
        start     = (state == ST_IDLE) && (pend_hi || req_valid);
        in_acc    = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    end

    // Length of the current phase in clocks minus one.
    always_comb begin
        case (state)
            ST_TURN:   phase_limit = cfg_turn;
            ST_SETUP:  phase_limit = cfg_setup;
            ST_STROBE: phase_limit = cfg_strobe;
            ST_HOLD:   phase_limit = cfg_hold;
            default:   phase_limit = '0;
        endcase
    end

    amc_turn_rule #(.CS_W(CS_W)) u_rule (
        .prev_valid (prev_valid),
        .prev_write (prev_write),
        .prev_cs    (prev_cs),
        .next_write (nxt_write),
        .next_cs    (nxt_cs),
        .need_turn  (need_turn)
    );

    amc_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .limit (phase_limit),
        .last  (phase_last)
    );

    amc_lane_mux #(.HALF_W(HALF_W)) u_lane (
        .wdata       (cur_wdata),
        .be          (cur_be),
        .upper       (upper),
        .write       (cur_write),
        .half_data   (half_data),
        .half_mask_n (half_mask_n)
    );

    // Phase sequencing, request capture, read capture and response pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_write  <= 1'b0;
            cur_wide   <= 1'b0;
            cur_cs     <= '0;
            cur_addr   <= '0;
            cur_wdata  <= '0;
            cur_be     <= '0;
            upper      <= 1'b0;
            pend_hi    <= 1'b0;
            prev_valid <= 1'b0;
            prev_write <= 1'b0;
            prev_cs    <= '0;
            rd_lo      <= '0;
            rd_hi      <= '0;
            rsp_q      <= 1'b0;
        end else begin
            rsp_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (!pend_hi) begin
                            cur_write <= req_write;
                            cur_wide  <= req_wide;
                            cur_cs    <= req_cs;
                            cur_addr  <= req_addr;
                            cur_wdata <= req_wdata;
                            cur_be    <= req_be;
                            upper     <= 1'b0;
                        end
                        pend_hi <= 1'b0;
                        state   <= need_turn ? ST_TURN : ST_SETUP;
                    end
                end
                ST_TURN: begin
                    if (phase_last) state <= ST_SETUP;
                end
                ST_SETUP: begin
                    if (phase_last) state <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (phase_last) begin
                        state <= ST_HOLD;
                        if (!cur_write) begin
                            if (upper) rd_hi <= mem_data;
                            else       rd_lo <= mem_data;
                        end
                    end
                end
                ST_HOLD: begin
                    if (phase_last) begin
                        state      <= ST_IDLE;
                        prev_valid <= 1'b1;
                        prev_write <= cur_write;
                        prev_cs    <= cur_cs;
                        if (cur_wide && !upper) begin
                            pend_hi <= 1'b1;
                            upper   <= 1'b1;
                        end else if (!cur_write) begin
                            rsp_q <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // One chip select per device, low only inside an access.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign mem_cs_n[g] = !(in_acc && (cur_cs == CS_W'(g)));
    end

    assign req_ready = (state == ST_IDLE) && !pend_hi;
    assign rsp_valid = rsp_q;
    assign rsp_rdata = {(cur_wide ? rd_hi : {HALF_W{1'b0}}), rd_lo};
    assign mem_oe_n  = !((state == ST_STROBE) && !cur_write);
    assign mem_we_n  = !((state == ST_STROBE) && cur_write);
    assign mem_dqm_n = in_acc ? half_mask_n : {LANES{1'b1}};
    assign mem_addr  = cur_addr + ADDR_W'(upper);
    assign mem_data  = (in_acc && cur_write) ? half_data : {HALF_W{1'bz}};

endmodule

// File: rtl/amc_checker.sv
// Module: protocol checker for amc_ctrl, attached by bind. It watches only
// top-level ports. Assumes synchronous active-low reset.
module amc_checker #(
    parameter int NUM_CS = 4,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [NUM_CS-1:0] mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [LANES-1:0]  mem_dqm_n
);

    logic any_cs;
    assign any_cs = !(&mem_cs_n);

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n)); // R7
    AST_CS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cs && $past(any_cs)) |-> $stable(mem_cs_n)); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R3
    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> any_cs); // R3
    AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(any_cs)); // R2
    AST_OE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> $past(any_cs)); // R2
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !any_cs); // R1
    AST_DQM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !any_cs |-> (mem_dqm_n == {LANES{1'b1}})); // R8
    AST_RSP_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!any_cs && $past(any_cs))); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10

endmodule

bind amc_ctrl amc_checker #(.NUM_CS(NUM_CS), .LANES(LANES)) u_amc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dqm_n (mem_dqm_n)
);

// File: tb/amc_ctrl_bench.sv
// Bench: random and directed requests against a reference memory; a bus
// monitor checks every access against a queue of expected halves.
module amc_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic [3:0]  cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0, cfg_turn = '0;
    logic        req_ready, rsp_valid, mem_oe_n, mem_we_n;
    logic [31:0] rsp_rdata;
    logic [3:0]  mem_cs_n;
    logic [1:0]  mem_dqm_n;
    logic [19:0] mem_addr;
    wire  [15:0] mem_data;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    amc_ctrl u_amc_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_wide(req_wide), .req_cs(req_cs),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_setup(cfg_setup),
        .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .cfg_turn(cfg_turn),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dqm_n(mem_dqm_n), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    // Device model and reference model, 64 halfwords per chip select.
    logic [15:0] dev_mem [4][64];
    logic [15:0] ref_mem [4][64];
    int          dev_cs;

    function automatic int cs_index(input logic [3:0] n);
        for (int i = 0; i < 4; i++) if (!n[i]) return i;
        return 0;
    endfunction

    assign dev_cs   = cs_index(mem_cs_n);
    assign mem_data = (!mem_oe_n) ? dev_mem[dev_cs][mem_addr[5:0]] : 16'hzzzz;

    // Expected half-access queue and expected response queue.
    logic [1:0]  q_cs [1024];
    logic [19:0] q_addr [1024];
    logic        q_wr [1024], q_last [1024], q_lo_of_wide [1024];
    logic [1:0]  q_mask [1024];
    logic [15:0] q_data [1024];
    int          q_head = 0, q_tail = 0;
    logic [31:0] r_data [1024];
    int          r_head = 0, r_tail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_gap(input logic [1:0] pcs, input logic pwr,
                                   input logic [1:0] ncs, input logic nwr,
                                   input logic [3:0] turn);
        if (pcs != ncs || (!pwr && nwr)) return 2 + int'(turn);
        return 1;
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] mask_n);
        return {mask_n[1] ? old[15:8] : nw[15:8], mask_n[0] ? old[7:0] : nw[7:0]};
    endfunction

    task automatic push_half(input logic [1:0] cs, input logic [19:0] addr, input logic wr,
                             input logic [1:0] mask_n, input logic [15:0] d,
                             input logic last, input logic lo_w);
        int k;
        k = q_tail & 1023;
        q_cs[k] = cs; q_addr[k] = addr; q_wr[k] = wr; q_mask[k] = mask_n;
        q_data[k] = d; q_last[k] = last; q_lo_of_wide[k] = lo_w;
        if (wr) ref_mem[cs][addr[5:0]] = merge(ref_mem[cs][addr[5:0]], d, mask_n);
        q_tail++;
    endtask

    // Offer one request, record expectations, return after it is taken.
    task automatic issue(input logic wr, input logic wide, input logic [1:0] cs,
                         input logic [19:0] addr, input logic [31:0] wd,
                         input logic [3:0] be);
        logic [3:0]  ebe;
        logic [15:0] lo, hi;
        ebe = wr ? be : 4'hF;
        req_valid = 1'b1; req_write = wr; req_wide = wide; req_cs = cs;
        req_addr = addr; req_wdata = wd; req_be = be;
        push_half(cs, addr, wr, wr ? ~ebe[1:0] : 2'b00, wd[15:0], !wide, wide);
        lo = ref_mem[cs][addr[5:0]];
        hi = 16'h0000;
        if (wide) begin
            push_half(cs, addr + 20'd1, wr, wr ? ~ebe[3:2] : 2'b00, wd[31:16], 1'b1, 1'b0);
            hi = ref_mem[cs][(addr[5:0] + 6'd1)];
        end
        if (!wr) begin
            r_data[r_tail & 1023] = {hi, lo};
            r_tail++;
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    // Bus monitor state.
    logic        in_acc = 1'b0, have_prev = 1'b0, gap_exact = 1'b0;
    int          ph = 0, n_set = 0, n_str = 0, n_hold = 0, gap = 0;
    logic [1:0]  e_cs, prev_cs;
    logic [19:0] e_addr;
    logic        e_wr, e_last, e_low, prev_wr;
    logic [1:0]  e_mask;
    logic [15:0] e_data;

    // Check every cycle of the external bus against the expected halves.
    always @(negedge clk) begin
        logic any, strobe, wrong, rsp_exp;
        rsp_exp = 1'b0;
        if (!rst_n) begin
            in_acc = 1'b0; have_prev = 1'b0; gap_exact = 1'b0; gap = 0;
        end else begin
            any = (mem_cs_n != 4'hF);
            if (!mem_we_n && any)
                dev_mem[dev_cs][mem_addr[5:0]] =
                    merge(dev_mem[dev_cs][mem_addr[5:0]], mem_data, mem_dqm_n);
            if (any) begin
                if (!in_acc) begin
                    chk(q_head != q_tail, "R1 access with no request", 32'd1, 32'd0);
                    e_cs = q_cs[q_head & 1023]; e_addr = q_addr[q_head & 1023];
                    e_wr = q_wr[q_head & 1023]; e_mask = q_mask[q_head & 1023];
                    e_data = q_data[q_head & 1023]; e_last = q_last[q_head & 1023];
                    e_low = q_lo_of_wide[q_head & 1023];
                    q_head++;
                    if (have_prev && gap_exact) begin
                        if (exp_gap(prev_cs, prev_wr, e_cs, e_wr, cfg_turn) > 1)
                            chk(gap == exp_gap(prev_cs, prev_wr, e_cs, e_wr, cfg_turn),
                                "R4 turnaround gap", gap, exp_gap(prev_cs, prev_wr, e_cs, e_wr, cfg_turn));
                        else
                            chk(gap == 1, "R5 no-turnaround gap", gap, 1);
                    end
                    in_acc = 1'b1; ph = 0; n_set = 0; n_str = 0; n_hold = 0;
                end
                chk(mem_cs_n == ~(4'b0001 << e_cs), "R7 chip select", mem_cs_n, ~(4'b0001 << e_cs));
                chk(mem_addr == e_addr, "R6 address", mem_addr, e_addr);
                chk(mem_dqm_n == e_mask, "R8 byte masks", mem_dqm_n, e_mask);
                if (e_wr) chk(mem_data == e_data, "R9 write data", mem_data, e_data);
                chk(!req_ready, "R1 ready during access", req_ready, 0);
                strobe = e_wr ? !mem_we_n : !mem_oe_n;
                wrong  = e_wr ? !mem_oe_n : !mem_we_n;
                chk(!wrong, "R3 wrong strobe", 1, 0);
                if (ph == 0 && strobe) ph = 1;
                else if (ph == 1 && !strobe) ph = 2;
                else if (ph == 2 && strobe) chk(0, "R2 strobe after hold", 1, 0);
                if (ph == 0) n_set++;
                else if (ph == 1) n_str++;
                else n_hold++;
            end else begin
                chk(mem_oe_n && mem_we_n && mem_dqm_n == 2'b11, "R3 R8 idle bus",
                    {mem_oe_n, mem_we_n, mem_dqm_n}, 4'hF);
                if (in_acc) begin
                    chk(n_set == cfg_setup + 1, "R2 setup length", n_set, cfg_setup + 1);
                    chk(n_str == cfg_strobe + 1, "R2 strobe length", n_str, cfg_strobe + 1);
                    chk(n_hold == cfg_hold + 1, "R2 hold length", n_hold, cfg_hold + 1);
                    if (e_low) chk(!req_ready, "R1 ready between halves", req_ready, 0);
                    rsp_exp = !e_wr && e_last;
                    prev_cs = e_cs; prev_wr = e_wr; have_prev = 1'b1;
                    gap = 1; gap_exact = (q_head != q_tail); in_acc = 1'b0;
                end else begin
                    gap++;
                end
            end
            chk(rsp_valid == rsp_exp, "R10 response timing", rsp_valid, rsp_exp);
            if (rsp_valid && rsp_exp) begin
                chk(rsp_rdata == r_data[r_head & 1023], "R10 read data",
                    rsp_rdata, r_data[r_head & 1023]);
                r_head++;
            end
        end
    end

    task automatic drain();
        @(negedge clk);
        while (q_head != q_tail || r_head != r_tail || in_acc) @(negedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int c = 0; c < 4; c++)
            for (int a = 0; a < 64; a++) begin
                dev_mem[c][a] = 16'(c * 4096 + a * 37);
                ref_mem[c][a] = 16'(c * 4096 + a * 37);
            end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11: idle outputs after reset
        chk(mem_cs_n == 4'hF, "R11 cs after reset", mem_cs_n, 4'hF);
        chk(mem_oe_n && mem_we_n, "R11 strobes after reset", {mem_oe_n, mem_we_n}, 2'b11);
        chk(mem_dqm_n == 2'b11, "R11 masks after reset", mem_dqm_n, 2'b11);
        chk(req_ready && !rsp_valid, "R11 handshake after reset", {req_ready, rsp_valid}, 2'b10);
        @(posedge clk); #1;
        cfg_setup = 4'd1; cfg_strobe = 4'd2; cfg_hold = 4'd0; cfg_turn = 4'd2;
        // Directed: every previous/next pairing of direction and chip select (R4, R5, R6).
        issue(0, 0, 2'd0, 20'd4,  32'h0, 4'h0);          // first access, no turnaround (R11)
        issue(0, 0, 2'd0, 20'd5,  32'h0, 4'h0);          // read-read same cs
        issue(1, 0, 2'd0, 20'd6,  32'h0000_A1B2, 4'h3);  // read-write same cs
        issue(1, 0, 2'd0, 20'd7,  32'h0000_C3D4, 4'h1);  // write-write same cs
        issue(0, 0, 2'd0, 20'd6,  32'h0, 4'h0);          // write-read same cs
        issue(0, 0, 2'd1, 20'd9,  32'h0, 4'h0);          // read-read other cs
        issue(1, 0, 2'd2, 20'd10, 32'h0000_5566, 4'h3);  // read-write other cs
        issue(1, 0, 2'd3, 20'd11, 32'h0000_7788, 4'h2);  // write-write other cs
        issue(0, 1, 2'd0, 20'd12, 32'h0, 4'h0);          // write-read other cs, split read
        issue(1, 1, 2'd1, 20'd20, 32'hDEAD_BEEF, 4'hB);  // split write, partial lanes
        issue(0, 1, 2'd1, 20'd20, 32'h0, 4'h0);          // read back the split write
        issue(0, 1, 2'd2, 20'd63, 32'h0, 4'h0);          // split read at top address
        drain();
        // Random batches with varied timing, including all-zero counts.
        for (int b = 0; b < 16; b++) begin
            cfg_setup  = (b == 0) ? 4'd0 : 4'($urandom % 4);
            cfg_strobe = (b == 0) ? 4'd0 : 4'($urandom % 4);
            cfg_hold   = (b == 0) ? 4'd0 : 4'($urandom % 4);
            cfg_turn   = (b == 0) ? 4'd0 : 4'($urandom % 4);
            for (int i = 0; i < 20; i++)
                issue(1'($urandom), 1'($urandom), 2'($urandom), 20'($urandom % 64),
                      $urandom, 4'($urandom));
            drain();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule